// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence controller of one private cache in a small multiprocessor whose caches share one bus. The cache is direct-mapped with one data word per line. Each line carries one of three states: Invalid, Shared (clean and readable, possibly held by several caches) or Exclusive (the only copy, writable and dirty with respect to memory). The cache writes back and keeps coherence by invalidation. Exclusive always means dirty. A write to a Shared line gets no upgrade shortcut and is handled as a full write miss.

On the CPU side a request either completes in the cycle it is presented or holds `cpu_stall` until the line has been fetched. On the bus side the controller raises `bus_req`. In a cycle where `bus_gnt` is high it drives one single-cycle transaction: a read miss, a write miss, or a write-back of a dirty victim. The bus carries only one transaction at a time. Every other controller observes it through its snoop inputs. A controller that holds the addressed block Exclusive answers in the same cycle with its dirty word, which memory captures and which the requester takes as fill data. It then downgrades its line (read miss) or invalidates it (write miss).

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is Invalid. `line_state` holds two bits per line, with line i at bits [2i+1:2i], encoded Invalid=0, Shared=1, Exclusive=2.
- R2: A CPU read whose tag matches a Shared or Exclusive line completes in the cycle it is presented. `cpu_stall` is low, `cpu_rdata` returns the line word and `bus_req` stays low.
- R3: A CPU read to an Invalid line or with a tag mismatch stalls and raises `bus_req`. When granted it drives `bus_cmd`=1 (read miss) with the request address. The line is filled from `bus_rdata` and becomes Shared, and the read completes in the following cycle.
- R4: A CPU write to a line not held Exclusive with a matching tag, including a Shared hit, drives `bus_cmd`=2 (write miss) when granted. The line becomes Exclusive with the write data. A write that hits Exclusive completes in one cycle with no bus request.
- R5: A snooped read miss (`snp_cmd`=1) to a block held Exclusive raises `snp_flush` in that cycle, with the dirty word on `snp_data`. The line then becomes Shared.
- R6: A snooped write miss (`snp_cmd`=2) to a block held Shared or Exclusive invalidates the line. If the line was Exclusive, the dirty word is supplied through `snp_flush`/`snp_data` in that cycle.
- R7: A miss whose line is Exclusive with a different tag first drives `bus_cmd`=3 (write-back) carrying the victim's address and word. It issues the read or write miss only in a later grant.
- R8: While `bus_gnt` is low, `bus_cmd`, `bus_addr` and `bus_wdata` are all zero.
- R9: When a snooped transaction addresses the same line index as a CPU access in the same cycle, the CPU access stalls in that cycle. It completes or misses against the updated state afterwards.
- R10: Across several controllers on one bus, no block is ever Exclusive in two caches, and every completed read returns the most recently completed write to its address.
- R11: A snooped transaction whose tag does not match the line, or whose line is Invalid, leaves the line state unchanged and does not raise `snp_flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until it completes |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Read data, valid when the access completes |
| cpu_stall | output | 1 | High while a request cannot complete this cycle |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant for this cycle |
| bus_cmd | output | 2 | 0 idle, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_rdata | input | DATA_W | Fill word from memory or from a flushing cache |
| snp_cmd | input | 2 | Transaction of another cache, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_flush | output | 1 | This cache supplies the dirty word of the snooped block |
| snp_data | output | DATA_W | Dirty word supplied on a flush |
| line_state | output | 2*LINES | State of every line, two bits each |

## Verification
The case that is hardest to reach is R9. A snoop must land on a line in the very cycle the local CPU presents an access that would otherwise hit, and the grant timing is set by the bus arbiter, not by the CPU. The bench starts a read on a second cache to a block the first cache holds Exclusive and waits for that cache's grant cycle. Only then does it present the first cache's read, so the stall, the flush and the downgrade all fall in one cycle. Write-backs before replacement and the exclusivity property of R10 are then driven hard by three controllers issuing random accesses to a small set of addresses that collide on the same lines.

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_stall,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic [1:0]         bus_cmd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic [1:0]         snp_cmd,
  input  logic [ADDR_W-1:0]  snp_addr,
  output logic               snp_flush,
  output logic [DATA_W-1:0]  snp_data,
  output logic [2*LINES-1:0] line_state
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RM = 2'd1, CMD_WM = 2'd2, CMD_WB = 2'd3;

  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  logic [1:0]       c_st, s_st, cmd_sel;
  logic             c_match, hit, conflict, cpu_done, need_wb, granted, snp_hit;

  assign c_idx    = cpu_addr[IDX_W-1:0];
  assign c_tag    = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx    = snp_addr[IDX_W-1:0];
  assign s_tag    = snp_addr[ADDR_W-1:IDX_W];
  assign c_st     = st_q[c_idx];
  assign s_st     = st_q[s_idx];
  assign c_match  = tag_q[c_idx] == c_tag;

  assign hit      = c_match && (cpu_we ? (c_st == ST_E) : (c_st != ST_I));
  assign conflict = (snp_cmd != CMD_NONE) && (s_idx == c_idx);
  assign cpu_done = cpu_req && hit && !conflict;
  assign cpu_stall = cpu_req && !cpu_done;
  assign cpu_rdata = dat_q[c_idx];

  assign bus_req  = cpu_req && !hit;
  assign granted  = bus_gnt && bus_req;
  assign need_wb  = (c_st == ST_E) && !c_match;
  assign cmd_sel  = need_wb ? CMD_WB : (cpu_we ? CMD_WM : CMD_RM);

  assign bus_cmd   = granted ? cmd_sel : CMD_NONE;
  assign bus_addr  = !granted ? '0 : (need_wb ? {tag_q[c_idx], c_idx} : cpu_addr);
  assign bus_wdata = (granted && need_wb) ? dat_q[c_idx] : '0;

  assign snp_hit   = ((snp_cmd == CMD_RM) || (snp_cmd == CMD_WM)) &&
                     (tag_q[s_idx] == s_tag) && (s_st != ST_I);
  assign snp_flush = snp_hit && (s_st == ST_E);
  assign snp_data  = snp_flush ? dat_q[s_idx] : '0;

  for (genvar g = 0; g < LINES; g++) begin : g_state
    assign line_state[2*g +: 2] = st_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_hit && s_idx == IDX_W'(i)) begin
          st_q[i] <= (snp_cmd == CMD_RM) ? ST_S : ST_I;
        end else if (granted && c_idx == IDX_W'(i)) begin
          unique case (cmd_sel)
            CMD_WB: st_q[i] <= ST_S;
            CMD_RM: begin
              st_q[i]  <= ST_S;
              tag_q[i] <= c_tag;
              dat_q[i] <= bus_rdata;
            end
            default: begin
              st_q[i]  <= ST_E;
              tag_q[i] <= c_tag;
              dat_q[i] <= cpu_wdata;
            end
          endcase
        end else if (cpu_done && cpu_we && c_idx == IDX_W'(i)) begin
          dat_q[i] <= cpu_wdata;
        end
      end
    end
  end

  AST_RESET_ALL_INVALID: assert property (@(posedge clk) $rose(rst_n) |-> line_state == '0); // R1
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_stall |-> !bus_req && !bus_gnt || !bus_req); // R2
  AST_READ_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == CMD_RM |=> st_q[$past(c_idx)] == ST_S); // R3
  AST_WRITE_MISS_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == CMD_WM |=> st_q[$past(c_idx)] == ST_E); // R4
  AST_FLUSH_DOWNGRADES: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> st_q[$past(s_idx)] != ST_E); // R5
  AST_WM_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    snp_cmd == CMD_WM && snp_hit |=> st_q[$past(s_idx)] == ST_I); // R6
  AST_NO_MISS_OVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_RM || bus_cmd == CMD_WM) |-> st_q[c_idx] != ST_E); // R7
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && snp_cmd != CMD_NONE && s_idx == c_idx |-> cpu_stall); // R9
endmodule

// File: tb/test_snoop_msi_ctrl.sv
`timescale 1ns/1ps
module test_snoop_msi_ctrl;
  localparam int A = 8, D = 16, L = 4, N = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic         req [N], we [N], stall [N], breq [N], sflush [N];
  logic [A-1:0] addr [N], baddr [N];
  logic [D-1:0] wdata [N], rdata [N], bwd [N], sdata [N];
  logic [1:0]   bcmd [N], scmd [N];
  logic [2*L-1:0] lstate [N];
  logic [N-1:0] gnt, gnt_nx;
  int           rr;

  logic [1:0]   any_cmd;
  logic [A-1:0] any_addr;
  logic [D-1:0] any_wd, fdata, fill;
  logic         fany;
  logic [D-1:0] mem [256];

  int checks = 0, fails = 0, cyc = 0;
  logic [D-1:0] ref_m [256];
  logic [A-1:0] shadow [N][L];
  logic [1:0]   lcmd [N][8];
  logic [A-1:0] laddr [N][8];
  logic [D-1:0] ldat [N][8];
  int           nlog [N];

  for (genvar k = 0; k < N; k++) begin : g_c
    snoop_msi_ctrl #(.ADDR_W(A), .DATA_W(D), .LINES(L)) i_snoop_msi_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[k]), .cpu_we(we[k]), .cpu_addr(addr[k]), .cpu_wdata(wdata[k]),
      .cpu_rdata(rdata[k]), .cpu_stall(stall[k]),
      .bus_req(breq[k]), .bus_gnt(gnt[k]), .bus_cmd(bcmd[k]), .bus_addr(baddr[k]),
      .bus_wdata(bwd[k]), .bus_rdata(fill),
      .snp_cmd(scmd[k]), .snp_addr(any_addr), .snp_flush(sflush[k]), .snp_data(sdata[k]),
      .line_state(lstate[k]));
  end

  always_comb begin
    any_cmd = '0; any_addr = '0; any_wd = '0; fany = 1'b0; fdata = '0;
    for (int k = 0; k < N; k++) begin
      any_cmd  = any_cmd | bcmd[k];
      any_addr = any_addr | baddr[k];
      any_wd   = any_wd | bwd[k];
      fany     = fany | sflush[k];
      fdata    = fdata | sdata[k];
    end
    for (int k = 0; k < N; k++) scmd[k] = gnt[k] ? 2'd0 : any_cmd;
    fill = fany ? fdata : mem[any_addr];
  end

  always_comb begin
    gnt_nx = '0;
    if (gnt == '0) begin
      for (int o = N - 1; o >= 0; o--) begin
        if (breq[(rr + o) % N]) begin
          gnt_nx = '0;
          gnt_nx[(rr + o) % N] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt <= '0; rr <= 0;
      for (int a = 0; a < 256; a++) mem[a] <= {8'hA5, 8'(a)};
    end else begin
      gnt <= gnt_nx;
      for (int k = 0; k < N; k++) if (gnt_nx[k]) rr <= (k + 1) % N;
      if (any_cmd == 2'd3) mem[any_addr] <= any_wd;
      if (fany) mem[any_addr] <= fdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] st(input int k, input int i);
    return lstate[k][2*i +: 2];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < N; k++)
        if (req[k] && !stall[k] && !we[k])
          chk(rdata[k] == ref_m[addr[k]], "R10 read returns latest write", rdata[k], ref_m[addr[k]]);
      for (int k = 0; k < N; k++)
        if (req[k] && !stall[k] && we[k]) ref_m[addr[k]] = wdata[k];
      for (int k = 0; k < N; k++)
        if (!gnt[k]) chk(bcmd[k] == 0 && baddr[k] == 0 && bwd[k] == 0,
                         "R8 bus quiet without grant", {bcmd[k], baddr[k]}, 0);
      for (int k = 0; k < N; k++)
        if (gnt[k] && bcmd[k] != 0) begin
          if (nlog[k] < 8) begin
            lcmd[k][nlog[k]] = bcmd[k]; laddr[k][nlog[k]] = baddr[k]; ldat[k][nlog[k]] = bwd[k];
            nlog[k]++;
          end
          if (bcmd[k] == 2'd1 || bcmd[k] == 2'd2) shadow[k][baddr[k] % L] = baddr[k];
        end
      begin
        int dup = 0;
        for (int i = 0; i < L; i++)
          for (int k = 0; k < N; k++)
            for (int j = k + 1; j < N; j++)
              if (st(k, i) == 2 && st(j, i) == 2 && shadow[k][i] == shadow[j][i]) dup++;
        chk(dup == 0, "R10 single Exclusive owner", dup, 0);
      end
    end
  end

  task automatic access(input int k, input bit w, input logic [A-1:0] a, input logic [D-1:0] v,
                        output logic [D-1:0] rd, output int lat);
    @(posedge clk); #1;
    nlog[k] = 0;
    req[k] = 1; we[k] = w; addr[k] = a; wdata[k] = v; lat = 0; rd = '0;
    forever begin
      @(negedge clk); lat++;
      if (!stall[k]) begin rd = rdata[k]; break; end
    end
    @(posedge clk); #1; req[k] = 0;
  endtask

  task automatic rnd_run(input int k, input int ops);
    logic [A-1:0] pool [6] = '{8'h10, 8'h14, 8'h18, 8'h11, 8'h15, 8'h23};
    logic [D-1:0] rd;
    int lat;
    for (int n = 0; n < ops; n++)
      access(k, 1'($urandom % 2), pool[$urandom % 6], D'($urandom), rd, lat);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [D-1:0] rd0, rd1;
  int lat0, lat1;

  initial begin
    void'($urandom(32'd11));
    for (int k = 0; k < N; k++) begin
      req[k] = 0; we[k] = 0; addr[k] = '0; wdata[k] = '0; nlog[k] = 0;
      for (int i = 0; i < L; i++) shadow[k][i] = '0;
    end
    for (int a = 0; a < 256; a++) ref_m[a] = {8'hA5, 8'(a)};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < N; k++) chk(lstate[k] == '0, "R1 reset all Invalid", lstate[k], 0);

    access(0, 0, 8'h10, 0, rd0, lat0);
    chk(lat0 > 1, "R3 read miss stalls", lat0, 3);
    chk(nlog[0] == 1 && lcmd[0][0] == 1 && laddr[0][0] == 8'h10, "R3 read miss command", lcmd[0][0], 1);
    chk(rd0 == 16'hA510, "R3 fill data", rd0, 16'hA510);
    chk(st(0, 0) == 1, "R3 line Shared after fill", st(0, 0), 1);

    access(0, 0, 8'h10, 0, rd0, lat0);
    chk(lat0 == 1 && nlog[0] == 0, "R2 read hit in one cycle without bus", lat0, 1);

    access(1, 1, 8'h10, 16'h1111, rd1, lat1);
    chk(nlog[1] == 1 && lcmd[1][0] == 2, "R4 write miss command", lcmd[1][0], 2);
    chk(st(1, 0) == 2, "R4 writer Exclusive", st(1, 0), 2);
    chk(st(0, 0) == 0, "R6 sharer invalidated", st(0, 0), 0);

    access(1, 1, 8'h10, 16'h2222, rd1, lat1);
    chk(lat1 == 1 && nlog[1] == 0, "R4 write hit in Exclusive", lat1, 1);

    access(0, 0, 8'h10, 0, rd0, lat0);
    chk(rd0 == 16'h2222, "R5 dirty word supplied", rd0, 16'h2222);
    chk(st(1, 0) == 1, "R5 owner downgraded to Shared", st(1, 0), 1);
    chk(mem[8'h10] == 16'h2222, "R5 memory updated by flush", mem[8'h10], 16'h2222);

    access(0, 1, 8'h10, 16'h3333, rd0, lat0);
    chk(nlog[0] == 1 && lcmd[0][0] == 2, "R4 Shared write is full write miss", lcmd[0][0], 2);
    chk(st(1, 0) == 0, "R6 other sharer invalidated", st(1, 0), 0);

    access(0, 1, 8'h14, 16'h4444, rd0, lat0);
    chk(nlog[0] == 2 && lcmd[0][0] == 3 && laddr[0][0] == 8'h10 && ldat[0][0] == 16'h3333,
        "R7 victim written back first", {lcmd[0][0], laddr[0][0]}, {2'd3, 8'h10});
    chk(lcmd[0][1] == 2 && laddr[0][1] == 8'h14, "R7 miss follows write-back", lcmd[0][1], 2);
    chk(mem[8'h10] == 16'h3333, "R7 memory holds victim", mem[8'h10], 16'h3333);

    fork
      access(1, 0, 8'h14, 0, rd1, lat1);
      begin
        forever begin @(posedge clk); #1; if (gnt[1]) break; end
        req[0] = 1; we[0] = 0; addr[0] = 8'h14;
        @(negedge clk);
        chk(stall[0] == 1, "R9 snoop on same line stalls CPU", stall[0], 1);
        @(negedge clk);
        chk(stall[0] == 0 && rdata[0] == 16'h4444, "R9 access re-evaluated after snoop", rdata[0], 16'h4444);
        chk(st(0, 0) == 1, "R9 line downgraded before CPU read", st(0, 0), 1);
        @(posedge clk); #1; req[0] = 0;
      end
    join
    chk(rd1 == 16'h4444, "R5 requester gets dirty word", rd1, 16'h4444);

    access(1, 1, 8'h18, 16'h5555, rd1, lat1);
    chk(st(0, 0) == 1, "R11 tag mismatch snoop ignored", st(0, 0), 1);
    access(0, 0, 8'h14, 0, rd0, lat0);
    chk(lat0 == 1 && rd0 == 16'h4444, "R11 line still usable", rd0, 16'h4444);

    fork
      rnd_run(0, 150);
      rnd_run(1, 150);
      rnd_run(2, 150);
    join

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule